// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers interrupt requests into one pending-status word and turns them into a single rising-edge interrupt line for the host processor. The word holds ten bits. The low four bits are live copies of the summary lines from four GPIO banks: bank A is bit 0, bank B is bit 1, bank C is bit 2 and bank D is bit 3. The six bits above them, bits 4 to 9, are sticky flags for six other peripheral sources. Source 0 sits at bit 4, and the sources go upward in index order.

A 16-bit register port gives access to two words. Address 0 is the status word and address 1 is the enable word. In the enable word, bits 4 to 9 are active-high enables for the six peripheral sources, and bit 15 is the global enable. The bank bits need no enable here, because the banks apply their own masks before driving a summary line.

The host sees an edge each time the set of enabled pending sources goes from empty to non-empty. Every write to the status word also forces the line low for one cycle. If anything enabled is still pending after that write, the line rises again, so the host receives a fresh edge for work that remains.

Top module: `irqAggTop`

## Requirements
- R1: After reset, `irqOut` is 0, all six sticky flags are 0 and the enable word reads 0x0000.
- R2: Reading address 0 returns `bankIrq[3:0]` in bits 3..0 with no delay, bank A in bit 0.
- R3: A high level on `srcIrq[i]` in a cycle sets status bit 4+i at the next clock edge. The bit stays set until it is cleared, whatever its enable.
- R4: A write to address 0 clears each bit 4..9 whose data bit is 1, and the read-back shows this from the next cycle. Data bits 0..3 and 10..15 of that write have no effect. Status bits 10..15 always read 0.
- R5: If a source is high in the same cycle as a write-1 clear of its bit, the bit is set after that edge.
- R6: A write to address 1 stores bits 4..9 as source enables (1 = enabled) and bit 15 as the global enable. The other bits read back as 0.
- R7: `irqOut` goes high one cycle after the global enable is 1 and either a bank line or an enabled sticky bit is set, provided no status write happens in that cycle.
- R8: `irqOut` stays 0 while the global enable is 0. A pending source whose enable bit is 0 does not raise `irqOut`.
- R9: `irqOut` is 0 in the cycle after any write to address 0. If enabled work is still pending, `irqOut` is 1 again one cycle later.
- R10: `irqOut` falls one cycle after nothing enabled is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 status, 1 enable |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the register selected by `regAddr` |
| bankIrq | input | 4 | Summary lines from GPIO banks A..D |
| srcIrq | input | 6 | Request lines from the six peripheral sources |
| irqOut | output | 1 | Rising-edge interrupt to the host |

## Verification
Two functions can fall in the same cycle:
- a source can set its sticky flag while software writes 1 to clear that same flag;
- a status write can land while other enabled work is still pending.

The bench provokes the first by driving a source and a clearing write in one cycle, both on a bit that is already set and on a bit that is clear. It then reads the status word and expects the set to win. It provokes the second by clearing only some bits, or only the bank bits, while enabled work stays pending. It expects one low cycle on `irqOut` followed by a new rise.

// File: rtl/irqAggPkg.sv
package irqAggPkg;

  // Register select values on regAddr
  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_ENABLE = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
  } regStrobeT;

endpackage

// File: rtl/irqAggDatapath.sv
module irqAggDatapath
  import irqAggPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_SRCS  = 6,
  parameter int DATA_W    = 16,
  parameter int GIE_BIT   = 15
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobeT                     strobe,
  input  logic                          regAddr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_BANKS-1:0]          bankIrq,
  input  logic [NUM_SRCS-1:0]           srcIrq,
  output logic [DATA_W-1:0]             rdData,
  output logic [NUM_BANKS+NUM_SRCS-1:0] statusView,
  output logic [DATA_W-1:0]             enableView,
  output logic                          pendAny
);

  localparam int STAT_W = NUM_BANKS + NUM_SRCS;
  localparam int PAD_W  = DATA_W - STAT_W;

  logic [NUM_SRCS-1:0] stickyQ;
  logic [NUM_SRCS-1:0] srcEnQ;
  logic                gieQ;

  // One sticky flag per peripheral source: a set beats a clear in the same cycle
  for (genvar i = 0; i < NUM_SRCS; i++) begin : g_sticky
    logic clrHit;
    assign clrHit = strobe.wrStatus & wrData[NUM_BANKS+i];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[i] <= 1'b0;
      else       stickyQ[i] <= srcIrq[i] | (stickyQ[i] & ~clrHit);
    end
  end

  // Enable word: source enables plus the global enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcEnQ <= '0;
      gieQ   <= 1'b0;
    end else if (strobe.wrEnable) begin
      srcEnQ <= wrData[NUM_BANKS +: NUM_SRCS];
      gieQ   <= wrData[GIE_BIT];
    end
  end

  // Bank bits are live copies of the summary lines
  assign statusView = {stickyQ, bankIrq};

  always_comb begin
    enableView                       = '0;
    enableView[NUM_BANKS +: NUM_SRCS] = srcEnQ;
    enableView[GIE_BIT]              = gieQ;
  end

  assign pendAny = gieQ & ((|bankIrq) | (|(stickyQ & srcEnQ)));

  always_comb begin
    if (regAddr == ADDR_ENABLE) rdData = enableView;
    else                        rdData = {{PAD_W{1'b0}}, statusView};
  end

endmodule

// File: rtl/irqAggControl.sv
module irqAggControl
  import irqAggPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      regAddr,
  input  logic      pendAny,
  output regStrobeT strobe,
  output logic      irqOut
);

  always_comb begin
    strobe.wrStatus = wrEn & (regAddr == ADDR_STATUS);
    strobe.wrEnable = wrEn & (regAddr == ADDR_ENABLE);
  end

  // A status write forces one low cycle so that pending work rises again
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= pendAny & ~strobe.wrStatus;
  end

endmodule

// File: rtl/irqAggTop.sv
module irqAggTop
  import irqAggPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_SRCS  = 6,
  parameter int DATA_W    = 16,
  parameter int GIE_BIT   = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic                 regAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  input  logic [NUM_BANKS-1:0] bankIrq,
  input  logic [NUM_SRCS-1:0]  srcIrq,
  output logic                 irqOut
);

  localparam int STAT_W = NUM_BANKS + NUM_SRCS;

  regStrobeT         strobe;
  logic              pendAny;
  logic [STAT_W-1:0] statusView;
  logic [DATA_W-1:0] enableView;

  irqAggControl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .regAddr (regAddr),
    .pendAny (pendAny),
    .strobe  (strobe),
    .irqOut  (irqOut)
  );

  irqAggDatapath #(
    .NUM_BANKS (NUM_BANKS),
    .NUM_SRCS  (NUM_SRCS),
    .DATA_W    (DATA_W),
    .GIE_BIT   (GIE_BIT)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regAddr    (regAddr),
    .wrData     (wrData),
    .bankIrq    (bankIrq),
    .srcIrq     (srcIrq),
    .rdData     (rdData),
    .statusView (statusView),
    .enableView (enableView),
    .pendAny    (pendAny)
  );

endmodule

// File: rtl/irqAggChecker.sv
module irqAggChecker
  import irqAggPkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int NUM_SRCS  = 6,
  parameter int DATA_W    = 16,
  parameter int GIE_BIT   = 15
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          regAddr,
  input logic [DATA_W-1:0]             rdData,
  input logic [NUM_SRCS-1:0]           srcIrq,
  input logic                          irqOut,
  input regStrobeT                     strobe,
  input logic                          pendAny,
  input logic [NUM_BANKS+NUM_SRCS-1:0] statusView,
  input logic [DATA_W-1:0]             enableView
);

  localparam int STAT_W = NUM_BANKS + NUM_SRCS;

  logic [NUM_SRCS-1:0] stickyQ;
  assign stickyQ = statusView[STAT_W-1:NUM_BANKS];

  assert_sticky_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrStatus |=> ((stickyQ & $past(stickyQ)) == $past(stickyQ)));

  assert_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_STATUS) |-> (rdData[DATA_W-1:STAT_W] == '0));

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rstN)
    (srcIrq != '0) |=> ((stickyQ & $past(srcIrq)) == $past(srcIrq)));

  assert_rise_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(pendAny));

  assert_gie_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> $past(enableView[GIE_BIT]));

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrStatus |=> !irqOut);

endmodule

bind irqAggTop irqAggChecker #(
  .NUM_BANKS (NUM_BANKS),
  .NUM_SRCS  (NUM_SRCS),
  .DATA_W    (DATA_W),
  .GIE_BIT   (GIE_BIT)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .regAddr    (regAddr),
  .rdData     (rdData),
  .srcIrq     (srcIrq),
  .irqOut     (irqOut),
  .strobe     (strobe),
  .pendAny    (pendAny),
  .statusView (statusView),
  .enableView (enableView)
);

// File: tb/irqAggTop_tb_top.sv
module irqAggTop_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] GIE = 16'h8000;
  localparam logic [15:0] ALL_SRC = 16'h03F0;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  bankIrq = '0;
  logic [5:0]  srcIrq = '0;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqAggTop dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .bankIrq(bankIrq), .srcIrq(srcIrq), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doWrite(input logic a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic pulseSrc(input logic [5:0] p);
    @(negedge clk);
    srcIrq = p;
    @(negedge clk);
    srcIrq = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual 0x0000 expected 0x0001");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step();

    // R1: reset state
    check("R1 irqOut", {15'b0, irqOut}, 16'h0);
    readReg(1'b0, r); check("R1 status", r, 16'h0);
    readReg(1'b1, r); check("R1 enable", r, 16'h0);

    // R6: enable word storage and unused bits
    doWrite(1'b1, 16'hFFFF);
    readReg(1'b1, r); check("R6 unused bits", r, GIE | ALL_SRC);
    doWrite(1'b1, 16'h0150);
    readReg(1'b1, r); check("R6 partial", r, 16'h0150);
    doWrite(1'b1, GIE | ALL_SRC);

    // R2, R7, R10: bank sweep
    for (int b = 0; b < 16; b++) begin
      @(negedge clk);
      bankIrq = b[3:0];
      readReg(1'b0, r); check("R2 bank live", r, {12'b0, b[3:0]});
      step();
      check((b != 0) ? "R7 bank rise" : "R10 bank idle", {15'b0, irqOut}, {15'b0, (b != 0)});
    end
    @(negedge clk); bankIrq = '0;
    step(); check("R10 fall", {15'b0, irqOut}, 16'h0);

    // R3, R4, R7, R10: source pattern sweep
    for (int p = 1; p < 64; p++) begin
      pulseSrc(p[5:0]);
      readReg(1'b0, r); check("R3 sticky", r, {6'b0, p[5:0], 4'b0});
      step(); check("R7 src rise", {15'b0, irqOut}, 16'h1);
      doWrite(1'b0, {6'b0, p[5:0], 4'b0});
      readReg(1'b0, r); check("R4 cleared", r, 16'h0);
      check("R9 low after write", {15'b0, irqOut}, 16'h0);
      step(); check("R10 stays low", {15'b0, irqOut}, 16'h0);
    end

    // R4, R9: partial clear with ignored data bits
    pulseSrc(6'h3F);
    step();
    doWrite(1'b0, 16'hFC1F);
    readReg(1'b0, r); check("R4 partial clear", r, 16'h03E0);
    check("R9 forced low", {15'b0, irqOut}, 16'h0);
    step(); check("R9 rises again", {15'b0, irqOut}, 16'h1);
    doWrite(1'b0, ALL_SRC);
    step();

    // R8, R3: per-source enable sweep
    for (int i = 0; i < 6; i++) begin
      doWrite(1'b1, GIE | (16'h0010 << i));
      for (int j = 0; j < 6; j++) begin
        pulseSrc(6'h01 << j);
        readReg(1'b0, r); check("R3 set while disabled", r, 16'h0010 << j);
        step();
        check("R8 enable gate", {15'b0, irqOut}, {15'b0, (i == j)});
        doWrite(1'b0, ALL_SRC);
        step();
      end
    end

    // R8: global enable off
    doWrite(1'b1, ALL_SRC);
    @(negedge clk); bankIrq = 4'hF;
    pulseSrc(6'h3F);
    step(); check("R8 gie off", {15'b0, irqOut}, 16'h0);
    readReg(1'b0, r); check("R2 R3 all pending", r, 16'h03FF);
    @(negedge clk); bankIrq = '0;
    doWrite(1'b0, ALL_SRC);

    // R5: set and clear in the same cycle
    @(negedge clk);
    wrEn = 1'b1; regAddr = 1'b0; wrData = ALL_SRC; srcIrq = 6'h05;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; srcIrq = '0;
    readReg(1'b0, r); check("R5 set wins fresh", r, 16'h0050);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 1'b0; wrData = 16'h0010; srcIrq = 6'h01;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; srcIrq = '0;
    readReg(1'b0, r); check("R5 set wins held", r, 16'h0050);
    doWrite(1'b0, ALL_SRC);

    // R9, R4: status write while a bank is pending
    doWrite(1'b1, GIE | ALL_SRC);
    @(negedge clk); bankIrq = 4'h2;
    step(); check("R7 bank B", {15'b0, irqOut}, 16'h1);
    doWrite(1'b0, 16'h000F);
    check("R9 bank low", {15'b0, irqOut}, 16'h0);
    readReg(1'b0, r); check("R4 bank unaffected", r, 16'h0002);
    step(); check("R9 bank re-rise", {15'b0, irqOut}, 16'h1);
    @(negedge clk); bankIrq = '0;
    step(); check("R10 final fall", {15'b0, irqOut}, 16'h0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule